// File: doc/BRIEF.md
# Serial Port Register Unit with Character Timing

This block is the register side of a serial communications port. A host bus reads and writes five byte-wide registers: a rate register, two control registers, a status register and a data register. Characters move at byte level. A received character arrives whole on a strobe. A transmitted character leaves whole on a strobe. An external bit-period tick paces each transmit frame. A frame lasts 10 or 11 ticks, depending on the character-length bit.

The transmit side is a two-state machine. `TX_IDLE` waits for a byte. The start transition `TX_IDLE -> TX_SEND` happens when the transmitter is enabled and a byte is either pending or being written that cycle. At start the byte is emitted, and the data-empty and transmit-complete flags drop. `TX_SEND` counts ticks. The frame-end transition `TX_SEND -> TX_IDLE` happens on the final tick of the frame and raises both flags again.

The receive side holds the latest character, a receive-full flag and an overrun flag. Clearing follows a two-step handshake. A status read snapshots the receive flags that are set. A later data read clears only those. A character arriving in between cancels the snapshot. The interrupt request combines four enable bits with their flags.

Top module: `sci_regfile`

## Requirements
- R1: After reset the rate register and both control registers read 0x00, and the status register (offset 3) reads 0xC0 (bit 7 data-empty, bit 6 transmit-complete, all other bits 0).
- R2: The rate (offset 0), control 1 (offset 1) and control 2 (offset 2) registers read back the last value written. Offsets 5 to 7 read 0x00. A write to the status register leaves its value unchanged.
- R3: A data register (offset 4) write while data-empty is set, with transmit-enable (control 2 bit 3) set and the machine in `TX_IDLE`, emits the byte on `tx_byte` with a one-cycle `tx_valid` on the next clock edge. It also clears status bits 7 and 6.
- R4: A data register write while data-empty is clear is ignored. No character is emitted for it, during or after the current frame.
- R5: A frame ends on the 10th bit tick after its start when control 1 bit 4 is clear, and on the 11th tick when it is set. Status bits 7 and 6 are set again at the frame end. The length is taken at frame start.
- R6: A byte written while transmit-enable is clear is held and not emitted, and status stays 0xC0. Setting transmit-enable afterwards starts its frame.
- R7: While receive-enable (control 2 bit 2) is set, a `rx_valid` pulse stores `rx_byte` and sets receive-full (status bit 5), and a data register read returns the byte. While it is clear, `rx_valid` is ignored.
- R8: A character that arrives while receive-full is set sets overrun (status bit 3) and replaces the stored byte.
- R9: A data register read clears exactly the receive flags that were set at the last status read. With no status read since the last arrival, a data read clears nothing.
- R10: `irq` = (ctl2[7] & bit7) | (ctl2[6] & bit6) | (ctl2[5] & (bit5 | bit3)) | (ctl2[4] & idle bit 4), where ctl2 is control 2 and the bit numbers refer to the status register. Bits 4, 2 and 1 of the status register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| bit_tick | input | 1 | One pulse per bit period |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | 8 | Received character |
| tx_valid | output | 1 | Transmitted character strobe |
| tx_byte | output | 8 | Transmitted character |
| irq | output | 1 | Interrupt request |

## Verification
The transmit machine is tested three ways. A write with the transmitter enabled starts at once. A write with it disabled waits until it is enabled. A write during a busy frame must vanish. Frames are run at both lengths, and the flags are sampled one tick before the end and again at the end, which catches an off-by-one tick count. On the receive side, single arrivals, back-to-back arrivals and arrivals with reception disabled show the overrun and ignore paths. The clear handshake is tried in three orders: status then data, data alone, and status, then an arrival, then data. This separates a correct snapshot from a blanket clear.

// File: rtl/sci_pkg.sv
package sci_pkg;
    // register offsets
    localparam int OFF_RATE = 0;
    localparam int OFF_CTL1 = 1;
    localparam int OFF_CTL2 = 2;
    localparam int OFF_STAT = 3;
    localparam int OFF_DATA = 4;

    // control 1
    localparam int C1_LONG = 4;
    // control 2
    localparam int C2_TXIE = 7;
    localparam int C2_DNIE = 6;
    localparam int C2_RXIE = 5;
    localparam int C2_IDIE = 4;
    localparam int C2_TXEN = 3;
    localparam int C2_RXEN = 2;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic full;
        logic idle;
        logic ovr;
        logic noise;
        logic frame;
    } rx_flags_t;
endpackage

// File: rtl/sci_tx_fsm.sv
module sci_tx_fsm
    import sci_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] frame_len,
    input  logic          bit_tick,
    output logic          empty_q,
    output logic          done_q,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte
);
    tx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, len_q;
    logic [DW-1:0] hold_q;
    logic          pend_q;
    logic          take, start, finish;

    assign take = wr_data && empty_q;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            TX_IDLE: if (tx_en && (pend_q || take)) begin
                start   = 1'b1;
                state_d = TX_SEND;
            end
            TX_SEND: if (bit_tick && (cnt_q == len_q - CW'(1))) begin
                finish  = 1'b1;
                state_d = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q  <= 1'b1;
            done_q   <= 1'b1;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            hold_q   <= '0;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            len_q    <= '0;
        end else if (start) begin
            empty_q  <= 1'b0;
            done_q   <= 1'b0;
            tx_valid <= 1'b1;
            tx_byte  <= take ? wdata : hold_q;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            len_q    <= frame_len;
        end else begin
            tx_valid <= 1'b0;
            if (take) begin
                pend_q <= 1'b1;
                hold_q <= wdata;
            end
            if (finish) begin
                empty_q <= 1'b1;
                done_q  <= 1'b1;
            end else if (state_q == TX_SEND && bit_tick) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    AST_START_DROPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (!empty_q && !done_q)); // R3
    AST_BUSY_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND && !finish) |=> !tx_valid); // R4
    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND) |-> (cnt_q < len_q)); // R5
    AST_FRAME_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (empty_q && done_q)); // R5
endmodule

// File: rtl/sci_rx_status.sv
module sci_rx_status
    import sci_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          stat_rd,
    input  logic          data_rd,
    output rx_flags_t     flags,
    output logic [DW-1:0] rx_data_q
);
    logic      full_q, ovr_q, arrive;
    rx_flags_t snap_q;

    assign arrive = rx_valid && rx_en;

    always_comb begin
        flags       = '0;
        flags.full  = full_q;
        flags.ovr   = ovr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q    <= 1'b0;
            ovr_q     <= 1'b0;
            snap_q    <= '0;
            rx_data_q <= '0;
        end else if (arrive) begin
            rx_data_q <= rx_byte;
            full_q    <= 1'b1;
            ovr_q     <= ovr_q | full_q;
            snap_q    <= '0;
        end else if (stat_rd) begin
            snap_q <= flags;
        end else if (data_rd) begin
            full_q <= full_q & ~snap_q.full;
            ovr_q  <= ovr_q & ~snap_q.ovr;
        end
    end

    AST_RX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |=> full_q); // R7
    AST_RX_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_en) |=> $stable(rx_data_q)); // R7
    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && full_q) |=> ovr_q); // R8
    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_q) |-> $past(data_rd)); // R9
endmodule

// File: rtl/sci_regfile.sv
module sci_regfile
    import sci_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 3,
    parameter int SHORT_LEN  = 10,
    parameter int LONG_LEN   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          bit_tick,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    output logic          irq
);
    localparam int CW = $clog2(LONG_LEN + 1);

    logic [DW-1:0] rate_q, ctl1_q, ctl2_q, stat_v, rx_data;
    logic [CW-1:0] frame_len;
    logic          wr, rd, empty, done;
    rx_flags_t     fl;

    assign wr = bus_sel && bus_wr;
    assign rd = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            ctl1_q <= '0;
            ctl2_q <= '0;
        end else if (wr) begin
            if (bus_addr == AW'(OFF_RATE)) rate_q <= bus_wdata;
            if (bus_addr == AW'(OFF_CTL1)) ctl1_q <= bus_wdata;
            if (bus_addr == AW'(OFF_CTL2)) ctl2_q <= bus_wdata;
        end
    end

    assign frame_len = ctl1_q[C1_LONG] ? CW'(LONG_LEN) : CW'(SHORT_LEN);

    sci_tx_fsm #(.DW(DW), .CW(CW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (ctl2_q[C2_TXEN]),
        .wr_data   (wr && bus_addr == AW'(OFF_DATA)),
        .wdata     (bus_wdata),
        .frame_len (frame_len),
        .bit_tick  (bit_tick),
        .empty_q   (empty),
        .done_q    (done),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte)
    );

    sci_rx_status #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (ctl2_q[C2_RXEN]),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .stat_rd   (rd && bus_addr == AW'(OFF_STAT)),
        .data_rd   (rd && bus_addr == AW'(OFF_DATA)),
        .flags     (fl),
        .rx_data_q (rx_data)
    );

    assign stat_v = {empty, done, fl.full, fl.idle, fl.ovr, fl.noise, fl.frame, 1'b0};

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (int'(bus_addr))
                OFF_RATE: bus_rdata = rate_q;
                OFF_CTL1: bus_rdata = ctl1_q;
                OFF_CTL2: bus_rdata = ctl2_q;
                OFF_STAT: bus_rdata = stat_v;
                OFF_DATA: bus_rdata = rx_data;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = (ctl2_q[C2_TXIE] & empty) | (ctl2_q[C2_DNIE] & done) |
                 (ctl2_q[C2_RXIE] & (fl.full | fl.ovr)) | (ctl2_q[C2_IDIE] & fl.idle);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl2_q[7:4] != 4'b0)); // R10
endmodule

// File: tb/sim_sci_regfile.sv
module sim_sci_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       bit_tick = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0, tx_byte;
    logic       tx_valid, irq;

    int checks = 0, fails = 0, tx_cnt = 0;
    logic [7:0] tx_last = '0;
    logic [7:0] v;
    bit done = 0;

    always #10 clk = ~clk;

    sci_regfile u0 (.*);

    always @(negedge clk) if (tx_valid) begin
        tx_cnt++;
        tx_last = tx_byte;
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #5 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1;
            @(posedge clk); #1; bit_tick = 0;
        end
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1; rx_byte = b;
        @(posedge clk); #1; rx_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd(0, v); check("R1 rate", v, 8'h00);
        rd(1, v); check("R1 ctl1", v, 8'h00);
        rd(2, v); check("R1 ctl2", v, 8'h00);
        rd(3, v); check("R1 status", v, 8'hC0);
    endtask

    task automatic t_regs;
        wr(0, 8'h33); rd(0, v); check("R2 rate", v, 8'h33);
        wr(1, 8'h2A); rd(1, v); check("R2 ctl1", v, 8'h2A);
        wr(1, 8'h00);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); check("R2 unmapped", v, 8'h00);
        end
        wr(3, 8'h00); rd(3, v); check("R2 status write", v, 8'hC0);
    endtask

    task automatic t_tx_disabled;
        int c0 = tx_cnt;
        wr(2, 8'h00); wr(4, 8'h5A); idle(3);
        check("R6 no emit", 8'(tx_cnt - c0), 8'd0);
        rd(3, v); check("R6 status", v, 8'hC0);
        wr(2, 8'h08); idle(2);
        check("R6 emit on enable", 8'(tx_cnt - c0), 8'd1);
        check("R6 byte", tx_last, 8'h5A);
        ticks(10);
        rd(3, v); check("R6 frame end", v, 8'hC0);
    endtask

    task automatic t_tx_basic;
        int c0 = tx_cnt;
        wr(4, 8'hA5); idle(1);
        check("R3 emit", 8'(tx_cnt - c0), 8'd1);
        check("R3 byte", tx_last, 8'hA5);
        rd(3, v); check("R3 flags drop", v, 8'h00);
        wr(4, 8'h11);
        ticks(9);
        rd(3, v); check("R5 busy after 9", v, 8'h00);
        ticks(1);
        rd(3, v); check("R5 done after 10", v, 8'hC0);
        idle(3);
        check("R4 ignored write", 8'(tx_cnt - c0), 8'd1);
        check("R4 byte kept", tx_last, 8'hA5);
    endtask

    task automatic t_tx_long;
        wr(1, 8'h10); wr(4, 8'h3C);
        ticks(10);
        rd(3, v); check("R5 long busy after 10", v, 8'h00);
        ticks(1);
        rd(3, v); check("R5 long done after 11", v, 8'hC0);
        wr(1, 8'h00);
    endtask

    task automatic t_rx;
        wr(2, 8'h24); rx(8'h3C);
        rd(3, v); check("R7 full", v, 8'hE0);
        check("R10 rx irq", {7'd0, irq}, 8'd1);
        rd(4, v); check("R7 data", v, 8'h3C);
        rd(3, v); check("R9 cleared", v, 8'hC0);
        check("R10 rx irq off", {7'd0, irq}, 8'd0);
        wr(2, 8'h00); rx(8'h77);
        rd(3, v); check("R7 disabled status", v, 8'hC0);
        rd(4, v); check("R7 disabled data", v, 8'h3C);
    endtask

    task automatic t_overrun;
        wr(2, 8'h04); rx(8'h01); rx(8'h02);
        rd(3, v); check("R8 overrun", v, 8'hE8);
        rd(4, v); check("R8 replaced", v, 8'h02);
        rd(3, v); check("R8 cleared", v, 8'hC0);
    endtask

    task automatic t_clear_seq;
        rx(8'h10);
        rd(4, v); check("R9 data only", v, 8'h10);
        rd(3, v); check("R9 no clear", v, 8'hE0);
        rx(8'h20);
        rd(4, v); check("R9 arrival cancels", v, 8'h20);
        rd(3, v); check("R9 flags kept", v, 8'hE8);
        rd(4, v);
        rd(3, v); check("R9 final clear", v, 8'hC0);
    endtask

    task automatic t_irq;
        wr(2, 8'h80); idle(1); check("R10 data-empty", {7'd0, irq}, 8'd1);
        wr(2, 8'h40); idle(1); check("R10 complete", {7'd0, irq}, 8'd1);
        wr(2, 8'h10); idle(1); check("R10 idle line", {7'd0, irq}, 8'd0);
        wr(2, 8'h00); idle(1); check("R10 none", {7'd0, irq}, 8'd0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset; t_regs; t_tx_disabled; t_tx_basic; t_tx_long;
        t_rx; t_overrun; t_clear_seq; t_irq;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule